// File: doc/BRIEF.md
# Multi-Event Modulo-100 Occurrence Counter

This block tracks how often each of 55 event types has happened. An event source presents at most one encoded event number per clock, qualified by a valid strobe. Each event type has its own modulo-100 counter. When an occurrence takes a counter from 99 back to 0, the block puts that event's number on a registered output for one cycle. In every other cycle the output is zero.

A downstream consumer uses the output as a compact "every hundredth occurrence" notification. A non-zero value names the event type that has just completed another hundred occurrences. There is no readback of the individual counts.

Top module: `evc_occurrence_counter`

## Requirements
- R1: While the active-low reset `rst_n` is low, every counter clears to 0 and `wrap_id` is 0. After reset is released, the next wrap of any event needs exactly 100 accepted occurrences of that event.
- R2: An accepted occurrence (`evt_valid`=1 and `evt_id` between 1 and 55) advances only the counter of event `evt_id`, by one.
- R3: A counter that holds 99 and receives an occurrence goes to 0. The same event can therefore never be reported in two consecutive cycles.
- R4: When the clock edge that accepts an occurrence makes a counter wrap, `wrap_id` equals that event's number for the following cycle only.
- R5: In every cycle not covered by R4, `wrap_id` is 0. This includes the cycles after reset before any wrap, so the reset value of the counters alone never raises the output.
- R6: While `evt_valid` is 0, no counter changes and `wrap_id` is 0 in the next cycle.
- R7: With `evt_valid`=1, an `evt_id` of 0 or of 56 to 63 is ignored. No counter changes and `wrap_id` is 0 in the next cycle.
- R8: The counters are independent of each other. Interleaved occurrences of different events each wrap on their own 100th occurrence.
- R9: `wrap_id` never exceeds 55.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| evt_valid | input | 1 | Qualifies `evt_id` in this cycle |
| evt_id | input | 6 | Encoded event number; 1 to 55 are valid |
| wrap_id | output | 6 | Number of the event whose counter just wrapped; 0 otherwise |

## Verification
The assertions assume that `evt_valid` and `evt_id` are stable around each rising edge. They also assume that a non-zero `wrap_id` can be traced back to the input of the previous cycle. That only holds if at most one event arrives per cycle, which the single encoded input already enforces. The directed stimulus drives the inputs on the falling edge and samples `wrap_id` on the next falling edge. It keeps a reference count per event in the bench. It deliberately supplies out-of-range numbers and idle cycles with stale numbers present, so the ignore paths are exercised within those assumptions.

// File: rtl/evc_pkg.sv
package evc_pkg;
  parameter int unsigned EVC_NUM_EVENTS = 55;
  parameter int unsigned EVC_MODULUS    = 100;
  localparam int unsigned EVC_ID_W      = $clog2(EVC_NUM_EVENTS + 1);
  localparam int unsigned EVC_CNT_W     = $clog2(EVC_MODULUS);
endpackage

// File: rtl/evc_decode.sv
module evc_decode #(
  parameter int unsigned NUM_EVENTS = 55,
  parameter int unsigned ID_W       = 6
) (
  input  logic                  valid_i,
  input  logic [ID_W-1:0]       id_i,
  output logic [NUM_EVENTS-1:0] hit_o
);
  // Event k+1 maps to hit bit k. Identifiers outside the range match no bit.
  for (genvar k = 0; k < NUM_EVENTS; k++) begin : g_hit
    assign hit_o[k] = valid_i && (id_i == ID_W'(k + 1));
  end
endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int unsigned MODULUS = 100,
  parameter int unsigned CNT_W   = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  output logic wrap_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MODULUS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == LAST);
  assign wrap_o  = inc_i && at_last;

  always_comb begin
    cnt_d = at_last ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/evc_wrap_encode.sv
module evc_wrap_encode #(
  parameter int unsigned NUM_EVENTS = 55,
  parameter int unsigned ID_W       = 6
) (
  input  logic [NUM_EVENTS-1:0] wrap_i,
  output logic [ID_W-1:0]       id_o
);
  // At most one bit is set per cycle, so OR-ing the numbers yields the winner.
  always_comb begin
    id_o = '0;
    for (int k = 0; k < NUM_EVENTS; k++) begin
      id_o = id_o | (wrap_i[k] ? ID_W'(k + 1) : '0);
    end
  end
endmodule

// File: rtl/evc_occurrence_counter.sv
module evc_occurrence_counter
  import evc_pkg::*;
#(
  parameter int unsigned NUM_EVENTS = EVC_NUM_EVENTS,
  parameter int unsigned MODULUS    = EVC_MODULUS,
  parameter int unsigned ID_W       = $clog2(NUM_EVENTS + 1),
  parameter int unsigned CNT_W      = $clog2(MODULUS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt_valid,
  input  logic [ID_W-1:0] evt_id,
  output logic [ID_W-1:0] wrap_id
);
  logic [NUM_EVENTS-1:0] hit;
  logic [NUM_EVENTS-1:0] wrap;
  logic [ID_W-1:0]       wrap_id_d;
  logic [ID_W-1:0]       wrap_id_q;

  evc_decode #(.NUM_EVENTS(NUM_EVENTS), .ID_W(ID_W)) u_decode (
    .valid_i (evt_valid),
    .id_i    (evt_id),
    .hit_o   (hit)
  );

  for (genvar k = 0; k < NUM_EVENTS; k++) begin : g_cnt
    evc_counter #(.MODULUS(MODULUS), .CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc_i  (hit[k]),
      .wrap_o (wrap[k])
    );
  end

  evc_wrap_encode #(.NUM_EVENTS(NUM_EVENTS), .ID_W(ID_W)) u_encode (
    .wrap_i (wrap),
    .id_o   (wrap_id_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_id_q <= '0;
    end else begin
      wrap_id_q <= wrap_id_d;
    end
  end

  assign wrap_id = wrap_id_q;
endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
  parameter int unsigned NUM_EVENTS = 55,
  parameter int unsigned ID_W       = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            evt_valid,
  input logic [ID_W-1:0] evt_id,
  input logic [ID_W-1:0] wrap_id
);
  logic id_bad;
  assign id_bad = (evt_id == '0) || (int'(evt_id) > int'(NUM_EVENTS));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> (wrap_id == '0));

  assert_bad_id_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && id_bad) |=> (wrap_id == '0));

  assert_report_traces_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_id != '0) |-> ($past(evt_valid) && ($past(evt_id) == wrap_id)));

  assert_no_repeat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_id != '0) |=> (wrap_id != $past(wrap_id)));

  assert_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wrap_id) <= int'(NUM_EVENTS));
endmodule

bind evc_occurrence_counter evc_checker #(.NUM_EVENTS(NUM_EVENTS), .ID_W(ID_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_valid (evt_valid),
  .evt_id    (evt_id),
  .wrap_id   (wrap_id)
);

// File: tb/sim_evc_occurrence_counter.sv
`timescale 1ns/1ps
module sim_evc_occurrence_counter;
  localparam int NE = 55;
  localparam int MOD = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       evt_valid = 1'b0;
  logic [5:0] evt_id = '0;
  logic [5:0] wrap_id;

  int n_checks = 0;
  int n_fails  = 0;
  int model [1:NE];
  bit done = 0;

  always #4 clk = ~clk;

  evc_occurrence_counter u0 (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_id(evt_id), .wrap_id(wrap_id)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: wrap_id actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drive on the falling edge, let one rising edge capture, compare on the next falling edge.
  task automatic send(input bit v, input int id, input string req);
    int exp;
    evt_valid = v;
    evt_id    = 6'(id);
    exp = 0;
    if (v && id >= 1 && id <= NE) begin
      if (model[id] == MOD - 1) begin
        model[id] = 0;
        exp = id;
      end else begin
        model[id]++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(req, int'(wrap_id), exp);
    if (int'(wrap_id) > NE) check("R9", int'(wrap_id), NE);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    evt_valid = 1'b0;
    for (int i = 1; i <= NE; i++) model[i] = 0;
    @(posedge clk);
    @(negedge clk);
    check("R1", int'(wrap_id), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_idle();
    do_reset();
    for (int i = 0; i < 5; i++) send(1'b0, 0, "R5");
  endtask

  task automatic t_single_wrap();
    for (int i = 0; i < MOD; i++) send(1'b1, 7, "R4");
    send(1'b1, 7, "R3");
    send(1'b0, 7, "R5");
  endtask

  task automatic t_ignored();
    for (int i = 0; i < 150; i++) send(1'b0, 12, "R6");
    for (int i = 0; i < 120; i++) send(1'b1, 0, "R7");
    for (int i = 0; i < 110; i++) send(1'b1, 56 + (i % 8), "R7");
    // Event 12 must still need exactly 100 occurrences to wrap.
    for (int i = 0; i < MOD; i++) send(1'b1, 12, "R2");
  endtask

  task automatic t_interleave();
    for (int i = 0; i < 2 * MOD + 10; i++) begin
      send(1'b1, 1, "R8");
      send(1'b1, NE, "R8");
      if (i % 3 == 0) send(1'b1, 30, "R8");
    end
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < 60; i++) send(1'b1, 3, "R2");
    do_reset();
    for (int i = 0; i < MOD + 2; i++) send(1'b1, 3, "R1");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    for (int i = 1; i <= NE; i++) model[i] = 0;
    #2;
    t_reset_idle();
    t_single_wrap();
    t_ignored();
    t_interleave();
    t_reset_mid();
    finish_run();
  end

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule